// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block is the tag side of a set-associative cache. Each way of each set records a line address, an access permission and an optional lock owner. A request presents a line-aligned address together with an operation and a request kind (load, instruction fetch or store). In the same cycle the block reports:
- whether the line is present, and in which way;
- whether the stored permission allows the request;
- whether the selected set can accept a new line;
- when the set is full, which resident line should be evicted;
- whether the querying context owns the line's lock.

State-changing operations take effect at the next rising clock edge. There are six of them: allocate, deallocate, permission write, lock set, lock clear, and a lookup that refreshes recency on a hit. A coherence controller drives this block. It decides what to do from the combinational answers and issues one operation per cycle. Recency is tracked as true LRU with a small age counter per way.

Top module: `perm_tag_dir`

## Requirements
- R1: The set is selected by address bits [IDX_LO +: log2(NUM_SETS)]. Addresses that differ in those bits never see each other's lines or recency state.
- R2: `hit` is 1 only when a way of the selected set holds `op_addr` with a permission other than absent. `hit_way` gives that way, and is 0 on a miss. Permission codes are: 0 absent, 1 invalid, 2 read-only, 3 read-write, 4 busy.
- R3: Request kinds are 0 load, 1 instruction fetch and 2 store. `grant` is 1 on a hit to a read-write line for any kind, and on a hit to a read-only line for kinds 0 and 1. All other hits, including a store to a read-only line, give `grant` 0.
- R4: `set_room` is 1 when at least one way of the selected set meets one of these conditions: it is empty, it is marked absent, or it holds `op_addr`.
- R5: `victim_valid` equals the inverse of `set_room`. While it is 1, `victim_addr` is the address in the least recently touched way of the set. Right after reset, a higher-numbered way counts as older than a lower-numbered one.
- R6: Allocate (op 1) fills the lowest-numbered way that is empty or absent. It stores the address, sets the permission to invalid (1) and leaves the lock with no owner. If the address is already present, or no way is empty or absent, `alloc_err` is 1 and no state changes.
- R7: A lookup (op 0) that hits makes that way the most recent. An allocate makes the new way the most recent only when `op_touch` is 1. No other operation changes recency.
- R8: Deallocate (op 2) of a present address empties its way. Deallocating an address that is not present has no effect.
- R9: Permission write (op 3) stores `op_perm` in the lowest way whose stored address equals `op_addr`, whatever the way's current permission. If no way holds the address, nothing changes.
- R10: Lock set (op 4) on a present line records `op_ctx` as owner, and lock clear (op 5) removes the owner. `lock_owned` is 1 only on a hit whose stored owner equals `op_ctx`. Both operations do nothing on a line that is not present.
- R11: Synchronous reset empties every way. All status outputs are combinational in the current inputs. An operation with `op_valid` 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 lookup, 1 allocate, 2 deallocate, 3 permission write, 4 lock set, 5 lock clear |
| op_addr | input | ADDR_W | Line-aligned address |
| op_req | input | 2 | Request kind: 0 load, 1 instruction fetch, 2 store |
| op_perm | input | 3 | Permission code written by op 3 |
| op_ctx | input | CTX_W | Context for lock set and lock test |
| op_touch | input | 1 | Allocate also refreshes recency |
| hit | output | 1 | Line present |
| hit_way | output | log2(NUM_WAYS) | Way of the present line |
| grant | output | 1 | Permission allows the request kind |
| set_room | output | 1 | Selected set can take the address |
| victim_valid | output | 1 | Set is full and a victim is offered |
| victim_addr | output | ADDR_W | Address held in the least recently used way |
| lock_owned | output | 1 | Present line is locked by `op_ctx` |
| alloc_err | output | 1 | Current allocate is refused |

## Verification
The bench sweeps every pairing of the five permission codes with the three request kinds. A design that grants stores on read-only lines, or counts an absent tag as a hit, fails on those pairs. A full set is driven through allocate retries and duplicate allocates, which exposes an allocator that overwrites a live way or mutates state while it reports the error. Dealloc-then-refill shows whether the freed slot is reused first. Long random runs against an arithmetic recency model check the victim after every touch, which exposes an age update that ages the wrong ways or refreshes on allocate without `op_touch`. Identical tags placed in different sets, a locked line probed from all eight contexts, and a disabled allocate round out the checks for set isolation, owner comparison and `op_valid` gating.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

    typedef enum logic [2:0] {
        PERM_ABSENT  = 3'd0,
        PERM_INVALID = 3'd1,
        PERM_RDONLY  = 3'd2,
        PERM_RDWR    = 3'd3,
        PERM_BUSY    = 3'd4
    } perm_e;

    typedef enum logic [1:0] {
        REQ_LOAD   = 2'd0,
        REQ_IFETCH = 2'd1,
        REQ_STORE  = 2'd2
    } req_e;

    typedef enum logic [2:0] {
        OP_LOOKUP  = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_DEALLOC = 3'd2,
        OP_SETPERM = 3'd3,
        OP_LOCK    = 3'd4,
        OP_UNLOCK  = 3'd5
    } op_e;

    // Read-write lets everything through; read-only lets only reads through.
    function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] req);
        return (perm == PERM_RDWR) ||
               ((perm == PERM_RDONLY) && ((req == REQ_LOAD) || (req == REQ_IFETCH)));
    endfunction

endpackage

// File: rtl/ptd_way_cmp.sv
module ptd_way_cmp #(
    parameter int ADDR_W = 12,
    parameter int CTX_W  = 3
) (
    input  logic              line_vld,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [2:0]        line_perm,
    input  logic              line_lck,
    input  logic [CTX_W-1:0]  line_owner,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              tag_eq,
    output logic              present,
    output logic              free,
    output logic              owned
);
    import ptd_pkg::*;

    logic absent;

    always_comb begin
        absent  = (line_perm == PERM_ABSENT);
        tag_eq  = line_vld && (line_addr == req_addr);
        present = tag_eq && !absent;
        free    = !line_vld || absent;
        owned   = line_lck && (line_owner == req_ctx);
    end

endmodule

// File: rtl/ptd_first_one.sv
module ptd_first_one #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Lowest set bit wins: scan from the top so the last write is the lowest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ptd_lru_age.sv
module ptd_lru_age #(
    parameter int WAYS  = 4,
    parameter int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic                       touch_en,
    input  logic [AGE_W-1:0]           touch_way,
    output logic [WAYS-1:0][AGE_W-1:0] age_out,
    output logic [AGE_W-1:0]           oldest_way
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

    logic [WAYS-1:0]  is_oldest;
    logic             oldest_found;
    logic [AGE_W-1:0] oldest_idx;
    logic [AGE_W-1:0] touched_age;

    always_comb begin
        touched_age = age_in[touch_way];
        for (int w = 0; w < WAYS; w++) begin
            if (!touch_en) begin
                age_out[w] = age_in[w];
            end else if (AGE_W'(w) == touch_way) begin
                age_out[w] = '0;
            end else if (age_in[w] < touched_age) begin
                age_out[w] = age_in[w] + AGE_W'(1);
            end else begin
                age_out[w] = age_in[w];
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_old
        assign is_oldest[w] = (age_in[w] == AGE_MAX);
    end

    ptd_first_one #(.N(WAYS), .IDX_W(AGE_W)) u_old_pick (
        .vec   (is_oldest),
        .found (oldest_found),
        .idx   (oldest_idx)
    );

    assign oldest_way = oldest_found ? oldest_idx : '0;

endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir #(
    parameter int ADDR_W   = 12,
    parameter int IDX_LO   = 2,
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int CTX_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        op_valid,
    input  logic [2:0]                  op_code,
    input  logic [ADDR_W-1:0]           op_addr,
    input  logic [1:0]                  op_req,
    input  logic [2:0]                  op_perm,
    input  logic [CTX_W-1:0]            op_ctx,
    input  logic                        op_touch,
    output logic                        hit,
    output logic [$clog2(NUM_WAYS)-1:0] hit_way,
    output logic                        grant,
    output logic                        set_room,
    output logic                        victim_valid,
    output logic [ADDR_W-1:0]           victim_addr,
    output logic                        lock_owned,
    output logic                        alloc_err
);
    import ptd_pkg::*;

    localparam int SET_W = $clog2(NUM_SETS);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int AGE_W = WAY_W;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        perm;
        logic              lck;
        logic [CTX_W-1:0]  owner;
    } line_t;

    typedef struct packed {
        line_t [NUM_SETS-1:0][NUM_WAYS-1:0]            line;
        logic  [NUM_SETS-1:0][NUM_WAYS-1:0][AGE_W-1:0] age;
    } dir_state_t;

    dir_state_t st_q, st_d, st_rst;

    logic [SET_W-1:0]                  set_idx;
    line_t [NUM_WAYS-1:0]              set_lines;
    logic [NUM_WAYS-1:0]               tag_v, pres_v, free_v, own_v;
    logic                              hit_i, has_free, tag_any;
    logic [WAY_W-1:0]                  hit_way_i, free_way, tag_way, oldest;
    logic                              alloc_req, alloc_bad, alloc_ok, lookup_hit;
    logic                              touch_en;
    logic [WAY_W-1:0]                  touch_way;
    logic [NUM_WAYS-1:0][AGE_W-1:0]    age_nxt;

    assign set_idx   = op_addr[IDX_LO +: SET_W];
    assign set_lines = st_q.line[set_idx];

    // Per-way comparators
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        ptd_way_cmp #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_cmp (
            .line_vld   (set_lines[w].vld),
            .line_addr  (set_lines[w].addr),
            .line_perm  (set_lines[w].perm),
            .line_lck   (set_lines[w].lck),
            .line_owner (set_lines[w].owner),
            .req_addr   (op_addr),
            .req_ctx    (op_ctx),
            .tag_eq     (tag_v[w]),
            .present    (pres_v[w]),
            .free       (free_v[w]),
            .owned      (own_v[w])
        );
    end

    ptd_first_one #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_hit_pick (
        .vec (pres_v), .found (hit_i), .idx (hit_way_i)
    );

    ptd_first_one #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_free_pick (
        .vec (free_v), .found (has_free), .idx (free_way)
    );

    ptd_first_one #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_tag_pick (
        .vec (tag_v), .found (tag_any), .idx (tag_way)
    );

    // Operation decode
    always_comb begin
        alloc_req  = op_valid && (op_code == OP_ALLOC);
        alloc_bad  = hit_i || !has_free;
        alloc_ok   = alloc_req && !alloc_bad;
        lookup_hit = op_valid && (op_code == OP_LOOKUP) && hit_i;
        touch_en   = lookup_hit || (alloc_ok && op_touch);
        touch_way  = lookup_hit ? hit_way_i : free_way;
    end

    ptd_lru_age #(.WAYS(NUM_WAYS), .AGE_W(AGE_W)) u_lru (
        .age_in     (st_q.age[set_idx]),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .age_out    (age_nxt),
        .oldest_way (oldest)
    );

    // Combinational answers
    always_comb begin
        hit          = hit_i;
        hit_way      = hit_way_i;
        grant        = hit_i && perm_allows(set_lines[hit_way_i].perm, op_req);
        set_room     = has_free || tag_any;
        victim_valid = !set_room;
        victim_addr  = victim_valid ? set_lines[oldest].addr : '0;
        lock_owned   = hit_i && own_v[hit_way_i];
        alloc_err    = alloc_req && alloc_bad;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        st_d.age[set_idx] = age_nxt;
        if (op_valid) begin
            case (op_code)
                OP_ALLOC: begin
                    if (alloc_ok) begin
                        st_d.line[set_idx][free_way].vld   = 1'b1;
                        st_d.line[set_idx][free_way].addr  = op_addr;
                        st_d.line[set_idx][free_way].perm  = PERM_INVALID;
                        st_d.line[set_idx][free_way].lck   = 1'b0;
                        st_d.line[set_idx][free_way].owner = '0;
                    end
                end
                OP_DEALLOC: begin
                    if (hit_i) begin
                        st_d.line[set_idx][hit_way_i] = '0;
                    end
                end
                OP_SETPERM: begin
                    if (tag_any) begin
                        st_d.line[set_idx][tag_way].perm = op_perm;
                    end
                end
                OP_LOCK: begin
                    if (hit_i) begin
                        st_d.line[set_idx][hit_way_i].lck   = 1'b1;
                        st_d.line[set_idx][hit_way_i].owner = op_ctx;
                    end
                end
                OP_UNLOCK: begin
                    if (hit_i) begin
                        st_d.line[set_idx][hit_way_i].lck = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Reset image: empty lines, ages ranked by way number
    always_comb begin
        st_rst = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                st_rst.age[s][w] = AGE_W'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/perm_tag_dir_chk.sv
module perm_tag_dir_chk #(
    parameter int ADDR_W = 12,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [ADDR_W-1:0] op_addr,
    input logic [2:0]        op_perm,
    input logic              hit,
    input logic              grant,
    input logic              set_room,
    input logic              lock_owned,
    input logic              alloc_err
);
    // R3: a grant only ever comes with a present line
    a_r3_grant_needs_hit: assert property (@(posedge clk) disable iff (rst)
        grant |-> hit);

    // R10: lock ownership is only reported for a present line
    a_r10_lock_needs_hit: assert property (@(posedge clk) disable iff (rst)
        lock_owned |-> hit);

    // R4: a present address always leaves room in its set
    a_r4_hit_has_room: assert property (@(posedge clk) disable iff (rst)
        hit |-> set_room);

    // R6: allocating a present address is refused
    a_r6_dup_alloc_err: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1 && hit) |-> alloc_err);

    // R6: an accepted allocate makes the address present next cycle
    a_r6_alloc_then_present: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd1 && !alloc_err) |=>
            ((op_addr != $past(op_addr)) || hit));

    // R8: deallocating a present address removes it
    a_r8_dealloc_then_gone: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd2 && hit) |=>
            ((op_addr != $past(op_addr)) || !hit));

    // R9: writing read-write onto a present line grants the next request
    a_r9_rw_write_grants: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'd3 && op_perm == 3'd3 && hit) |=>
            ((op_addr != $past(op_addr)) || grant));

endmodule

bind perm_tag_dir perm_tag_dir_chk #(.ADDR_W(ADDR_W), .WAY_W($clog2(NUM_WAYS))) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_addr    (op_addr),
    .op_perm    (op_perm),
    .hit        (hit),
    .grant      (grant),
    .set_room   (set_room),
    .lock_owned (lock_owned),
    .alloc_err  (alloc_err)
);

// File: tb/perm_tag_dir_tb.sv
module perm_tag_dir_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SETS = 4;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [11:0] op_addr = '0;
    logic [1:0]  op_req = '0;
    logic [2:0]  op_perm = '0;
    logic [2:0]  op_ctx = '0;
    logic        op_touch = 1'b0;
    logic        hit;
    logic [1:0]  hit_way;
    logic        grant, set_room, victim_valid, lock_owned, alloc_err;
    logic [11:0] victim_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    perm_tag_dir u_dut (
        .clk (clk), .rst (rst), .op_valid (op_valid), .op_code (op_code),
        .op_addr (op_addr), .op_req (op_req), .op_perm (op_perm),
        .op_ctx (op_ctx), .op_touch (op_touch), .hit (hit), .hit_way (hit_way),
        .grant (grant), .set_room (set_room), .victim_valid (victim_valid),
        .victim_addr (victim_addr), .lock_owned (lock_owned), .alloc_err (alloc_err)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // Reference state
    bit mv  [SETS][WAYS];
    int ma  [SETS][WAYS];
    int mp  [SETS][WAYS];
    bit mlk [SETS][WAYS];
    int mown[SETS][WAYS];
    int mts [SETS][WAYS];
    int now = 0;

    function automatic int A(input int tag, input int set);
        return (tag << 4) | (set << 2);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int got, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s got=%0h exp=%0h", rq, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mv[s][w] = 0; ma[s][w] = 0; mp[s][w] = 0;
                mlk[s][w] = 0; mown[s][w] = 0; mts[s][w] = -w;
            end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One operation: drive, check every output against the model, update model.
    task automatic step(input int op, input int addr, input int req, input int perm,
                        input int ctx, input bit touch, input bit vld, input string rq);
        int s, hw, fw, tw, vw, mints;
        bit ehit, egrant, eroom, elock, eerr;
        @(negedge clk);
        op_valid = vld; op_code = 3'(op); op_addr = 12'(addr); op_req = 2'(req);
        op_perm = 3'(perm); op_ctx = 3'(ctx); op_touch = touch;
        #2;
        s = (addr >> 2) & 3;
        hw = -1; fw = -1; tw = -1; vw = 0; mints = 32'h7fffffff;
        eroom = 0;
        for (int w = 0; w < WAYS; w++) begin
            if (hw < 0 && mv[s][w] && ma[s][w] == addr && mp[s][w] != 0) hw = w;
            if (fw < 0 && (!mv[s][w] || mp[s][w] == 0)) fw = w;
            if (tw < 0 && mv[s][w] && ma[s][w] == addr) tw = w;
            if (!mv[s][w] || mp[s][w] == 0 || ma[s][w] == addr) eroom = 1;
            if (mts[s][w] < mints) begin mints = mts[s][w]; vw = w; end
        end
        ehit   = (hw >= 0);
        egrant = ehit && (mp[s][hw] == 3 || (mp[s][hw] == 2 && req < 2));
        elock  = ehit && mlk[s][hw] && mown[s][hw] == ctx;
        eerr   = vld && op == 1 && (ehit || fw < 0);
        chk(hit == ehit, {"R2 ", rq}, "hit", int'(hit), int'(ehit));
        if (ehit) chk(int'(hit_way) == hw, {"R2 ", rq}, "hit_way", int'(hit_way), hw);
        chk(grant == egrant, {"R3 ", rq}, "grant", int'(grant), int'(egrant));
        chk(set_room == eroom, {"R4 ", rq}, "set_room", int'(set_room), int'(eroom));
        chk(victim_valid == !eroom, {"R5 ", rq}, "victim_valid", int'(victim_valid), int'(!eroom));
        if (!eroom)
            chk(int'(victim_addr) == ma[s][vw], {"R5 R7 ", rq}, "victim_addr",
                int'(victim_addr), ma[s][vw]);
        chk(lock_owned == elock, {"R10 ", rq}, "lock_owned", int'(lock_owned), int'(elock));
        chk(alloc_err == eerr, {"R6 ", rq}, "alloc_err", int'(alloc_err), int'(eerr));
        if (vld) begin
            now++;
            case (op)
                0: if (ehit) mts[s][hw] = now;
                1: if (!eerr) begin
                       mv[s][fw] = 1; ma[s][fw] = addr; mp[s][fw] = 1;
                       mlk[s][fw] = 0; mown[s][fw] = 0;
                       if (touch) mts[s][fw] = now;
                   end
                2: if (ehit) begin
                       mv[s][hw] = 0; ma[s][hw] = 0; mp[s][hw] = 0; mlk[s][hw] = 0; mown[s][hw] = 0;
                   end
                3: if (tw >= 0) mp[s][tw] = perm;
                4: if (ehit) begin mlk[s][hw] = 1; mown[s][hw] = ctx; end
                5: if (ehit) mlk[s][hw] = 0;
                default: ;
            endcase
        end
    endtask

    task automatic look(input int addr, input int req, input int ctx, input string rq);
        step(0, addr, req, 0, ctx, 0, 1, rq);
    endtask

    initial begin
        do_reset();

        // R11: empty after reset, in every set
        for (int s = 0; s < SETS; s++) look(A(3, s), 0, 0, "R11 reset");

        // R6: fill set 1, ways taken lowest first; tag 3 without touch
        step(1, A(1, 1), 0, 0, 0, 1, 1, "R6 fill");
        step(1, A(2, 1), 0, 0, 0, 1, 1, "R6 fill");
        step(1, A(3, 1), 0, 0, 0, 0, 1, "R6 R7 no-touch");
        step(1, A(4, 1), 0, 0, 0, 1, 1, "R6 fill");
        step(1, A(5, 1), 0, 0, 0, 1, 1, "R6 full");
        step(1, A(2, 1), 0, 0, 0, 1, 1, "R6 duplicate");
        look(A(5, 1), 0, 0, "R5 victim");

        // R1: same tags in another set are separate
        look(A(1, 2), 0, 0, "R1 isolation");
        step(1, A(1, 2), 0, 0, 0, 1, 1, "R1 other set");
        look(A(1, 2), 0, 0, "R1 other set hit");
        look(A(5, 1), 0, 0, "R1 victim kept");

        // R11: disabled allocate changes nothing
        step(1, A(6, 3), 0, 0, 0, 1, 0, "R11 gated");
        look(A(6, 3), 0, 0, "R11 gated");

        // R3 R9: every permission against every request kind
        for (int p = 0; p < 5; p++) begin
            step(3, A(1, 1), 0, p, 0, 0, 1, "R9 write");
            for (int k = 0; k < 3; k++) look(A(1, 1), k, 0, "R3 sweep");
        end
        step(3, A(9, 1), 0, 3, 0, 0, 1, "R9 no match");
        look(A(9, 1), 0, 0, "R9 no match");
        step(3, A(1, 1), 0, 2, 0, 0, 1, "R9 restore");

        // R7: hits reorder recency, victim follows
        look(A(4, 1), 0, 0, "R7 touch");
        look(A(1, 1), 0, 0, "R7 touch");
        look(A(9, 1), 0, 0, "R7 victim");

        // R10: lock owner sweep
        step(4, A(2, 1), 0, 0, 5, 0, 1, "R10 set");
        for (int c = 0; c < 8; c++) look(A(2, 1), 0, c, "R10 owner sweep");
        step(5, A(2, 1), 0, 0, 0, 0, 1, "R10 clear");
        look(A(2, 1), 0, 5, "R10 cleared");
        step(4, A(9, 1), 0, 0, 5, 0, 1, "R10 absent");

        // R8: dealloc and refill reuses the freed way
        step(2, A(9, 1), 0, 0, 0, 0, 1, "R8 absent");
        step(2, A(3, 1), 0, 0, 0, 0, 1, "R8 remove");
        look(A(3, 1), 0, 0, "R8 gone");
        step(1, A(7, 1), 0, 0, 0, 1, 1, "R8 R6 refill");
        look(A(7, 1), 0, 0, "R8 refill way");

        // R4 R6: absent-marked way counts as free and is reused
        step(3, A(2, 1), 0, 0, 0, 0, 1, "R4 absent mark");
        look(A(2, 1), 0, 0, "R2 absent not hit");
        step(1, A(8, 1), 0, 0, 0, 1, 1, "R6 reuse absent");

        // Random sweep over a small address space
        for (int i = 0; i < 4000; i++) begin
            int op, rq, pr;
            op = $urandom % 6;
            rq = $urandom % 3;
            pr = $urandom % 5;
            step(op, A($urandom % 6, $urandom % 4), rq, pr, $urandom % 8,
                 1'($urandom % 2), 1'(($urandom % 8) != 0), "random");
        end

        // R11: reset mid-run empties everything
        do_reset();
        for (int s = 0; s < SETS; s++)
            for (int t = 0; t < 6; t++) look(A(t, s), 0, 0, "R11 re-reset");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired got=1 exp=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule